// File: doc/BRIEF.md
# Serial DAC Command Frame Writer

This block sits on the host side of a three-wire link to a serial digital-to-analog converter. A client offers a 16-bit output code and a 2-bit power mode through a valid/ready handshake. The block packs them into a 24-bit command word, shifts it out most significant bit first on a data line, and generates the serial clock. When the last bit has been taken by the converter, it pulses a one-cycle completion flag.

The frame-select line is kept low while no transfer is running, which saves power in the receiver's input buffer. Each transfer begins with a high pulse on frame-select. The pulse length is a whole number of system cycles, rounded up from a 33 ns minimum. The line then falls to open the frame. The serial clock rests high. Data change only on its rising edge, so the receiver samples a settled bit on every falling edge, and all 24 falling edges land inside the frame. The half period of the serial clock is a parameter in system cycles, chosen to keep the link at or below 30 MHz.

Top module: `dac_frame_writer`

## Requirements
- R1: The 24-bit word is sent most significant bit first. Bits 23 down to 18 are zero, bits 17:16 carry the power mode and bits 15:0 carry the code.
- R2: The mode field is passed through unchanged: 00 runs the converter, 01 parks its output on about 1 kOhm to ground, 10 on about 100 kOhm to ground, and 11 leaves it floating.
- R3: Frame-select is low outside transfers. Before each frame it is high for exactly SYNC_HIGH_CYC system cycles, the 33 ns minimum divided by the clock period and rounded up (4 at defaults). It rises in the cycle after acceptance.
- R4: The serial clock rests high and toggles every SCLK_HALF_CYC system cycles (2 at defaults). A frame has exactly 24 falling edges, all while frame-select is low, and the first falling edge comes SCLK_HALF_CYC cycles after frame-select falls.
- R5: While the serial clock is low inside a frame, the data line does not change.
- R6: A request is taken only while req_ready is high, which happens only when no transfer is in progress. A request raised during a transfer has no effect on the word being sent and starts no further frame.
- R7: busy is high from the cycle after acceptance until the edge of the 24th falling serial clock edge. At that edge busy drops and done goes high for exactly one cycle, SYNC_HIGH_CYC + 47*SCLK_HALF_CYC cycles after acceptance (98 at defaults).
- R8: While reset is held and after it is released, frame-select is low, the serial clock is high, data is low, busy and done are low and req_ready is high.
- R9: The serial clock is back high SCLK_HALF_CYC cycles after done. At that point req_ready is high, frame-select is low and data is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Client offers a new command |
| req_code | input | 16 | Output code to send |
| req_mode | input | 2 | Power mode field |
| req_ready | output | 1 | High when a request would be accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the last bit has been clocked |
| dac_sync | output | 1 | Frame-select line to the converter |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_din | output | 1 | Serial data to the converter |

## Verification
Counting from the acceptance edge at defaults: frame-select rises one cycle later and stays high for four cycles. The first serial clock fall comes six cycles after acceptance, and done is due 98 cycles after it. The serial clock and req_ready are expected high two cycles after done. A monitor samples every output on the falling system clock edge, counting cycles from the rise of busy and collecting bits on each falling serial clock edge. Each latency is compared against these exact cycle numbers, never against a window. Frame contents, edge counts, pulse width and data stability are checked only after the completion pulse has been seen and one more cycle has passed, so the bench never reads the monitor in the same step it updates.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } wr_state_t;

  localparam int WORD_W = 24;

endpackage

// File: rtl/dacw_rst_sync.sv
module dacw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/dacw_sclk_gen.sv
module dacw_sclk_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tick,
  output logic rise_tick
);

  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick      = run && (div_q == DIV_LAST);
  assign fall_tick = tick && sclk_q;
  assign rise_tick = tick && !sclk_q;

  always_comb begin
    div_d  = div_q;
    sclk_d = sclk_q;
    if (!run) begin
      div_d  = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      div_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      div_d  = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  // R4: a falling serial edge only happens while the generator runs
  assert_sclk_fall_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> $past(run));

  // R4: with the generator stopped the clock returns to its resting level
  assert_sclk_rest_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk_q);

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  input  logic             shift,
  output logic             msb
);

  logic [WIDTH-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load) begin
      sreg_d = word;
    end else if (shift) begin
      sreg_d = {sreg_q[WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else begin
      sreg_q <= sreg_d;
    end
  end

  assign msb = sreg_q[WIDTH-1];

  // R1: a load presents the top bit of the new word on the next cycle
  assert_load_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(word[WIDTH-1])));

endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
#(
  parameter int SYNC_CYC = 4,
  parameter int BITS     = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fall_tick,
  input  logic rise_tick,
  output logic accept,
  output logic ready,
  output logic run,
  output logic sync,
  output logic busy,
  output logic done
);

  localparam int PC_W = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
  localparam int BC_W = $clog2(BITS);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(SYNC_CYC - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BITS - 1);

  wr_state_t       state_q, state_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            sync_q, sync_d;
  logic            busy_q, busy_d;
  logic            done_q, done_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready && req_valid;
  assign run    = (state_q == ST_SHIFT) || (state_q == ST_TAIL);

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    bcnt_d  = bcnt_q;
    sync_d  = sync_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_PULSE;
          pcnt_d  = '0;
          sync_d  = 1'b1;
          busy_d  = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pcnt_q == PC_LAST) begin
          state_d = ST_SHIFT;
          sync_d  = 1'b0;
          bcnt_d  = '0;
        end else begin
          pcnt_d = pcnt_q + PC_W'(1);
        end
      end
      ST_SHIFT: begin
        if (fall_tick) begin
          if (bcnt_q == BC_LAST) begin
            state_d = ST_TAIL;
            busy_d  = 1'b0;
            done_d  = 1'b1;
          end else begin
            bcnt_d = bcnt_q + BC_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (rise_tick) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      bcnt_q  <= '0;
      sync_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      bcnt_q  <= bcnt_d;
      sync_q  <= sync_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign sync = sync_q;
  assign busy = busy_q;
  assign done = done_q;

  // R3: an accepted request raises frame-select and busy on the next cycle
  assert_accept_starts_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sync_q && busy_q));

  // R3: frame-select is low whenever the controller rests
  assert_sync_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sync_q);

  // R6: no acceptance while a transfer is running
  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !accept);

  // R7: done lasts one cycle and never overlaps busy
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R7: done follows a falling serial edge seen in the cycle before
  assert_done_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(fall_tick));

endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer #(
  parameter int CLK_PERIOD_PS     = 10000,
  parameter int SYNC_MIN_HIGH_PS  = 33000,
  parameter int SCLK_HALF_CYC     = 2,
  parameter int CODE_W            = 16,
  parameter int MODE_W            = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [MODE_W-1:0] req_mode,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              dac_sync,
  output logic              dac_sclk,
  output logic              dac_din
);

  localparam int WORD_W        = dacw_pkg::WORD_W;
  localparam int PAD_W         = WORD_W - MODE_W - CODE_W;
  localparam int SYNC_HIGH_RAW = (SYNC_MIN_HIGH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SYNC_HIGH_CYC = (SYNC_HIGH_RAW < 1) ? 1 : SYNC_HIGH_RAW;

  logic              rst_sync_n;
  logic              accept;
  logic              run;
  logic              fall_tick;
  logic              rise_tick;
  logic [WORD_W-1:0] word;

  assign word = {{PAD_W{1'b0}}, req_mode, req_code};

  dacw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dacw_ctrl #(
    .SYNC_CYC (SYNC_HIGH_CYC),
    .BITS     (WORD_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .accept    (accept),
    .ready     (req_ready),
    .run       (run),
    .sync      (dac_sync),
    .busy      (busy),
    .done      (done)
  );

  dacw_sclk_gen #(
    .HALF_CYC (SCLK_HALF_CYC)
  ) u_sclk_gen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .sclk      (dac_sclk),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  dacw_shifter #(
    .WIDTH (WORD_W)
  ) u_shifter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (accept),
    .word  (word),
    .shift (rise_tick),
    .msb   (dac_din)
  );

  // R5: data hold while the serial clock stays low
  assert_din_stable_low_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!dac_sclk && $past(!dac_sclk)) |-> $stable(dac_din));

  // R4: no serial clock activity while frame-select is high
  assert_sclk_high_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dac_sync |-> dac_sclk);

endmodule

// File: tb/dac_frame_writer_tb.sv
module dac_frame_writer_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_code;
  logic [1:0]  req_mode;
  logic        req_ready, busy, done, dac_sync, dac_sclk, dac_din;

  localparam int SYNC_EXP = 4;
  localparam int HALF_EXP = 2;
  localparam int LAT_EXP  = SYNC_EXP + 47 * HALF_EXP;
  localparam int NVEC     = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b00, 16'h0000}, {2'b01, 16'hFFFF}, {2'b10, 16'hA5C3},
    {2'b11, 16'h0001}, {2'b00, 16'h8000}, {2'b11, 16'h7FFE}
  };

  int n_chk = 0;
  int n_bad = 0;

  dac_frame_writer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_mode  (req_mode),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .dac_sync  (dac_sync),
    .dac_sclk  (dac_sclk),
    .dac_din   (dac_din)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor state, written only by the monitor process
  logic [23:0] cap;
  int falls, cyc, done_at, done_cnt, sync_w, sync_w_last, sync_rises;
  int glitches, bad_falls, wd;
  logic p_sclk, p_sync, p_busy, p_din;

  initial begin
    cap = '0; falls = 0; cyc = 0; done_at = -1; done_cnt = 0;
    sync_w = 0; sync_w_last = 0; sync_rises = 0; glitches = 0;
    bad_falls = 0; wd = 0; p_sclk = 1'b1; p_sync = 1'b0; p_busy = 1'b0; p_din = 1'b0;
  end

  always @(negedge clk) begin
    wd = wd + 1;
    if (busy && !p_busy) begin
      cap = '0; falls = 0; cyc = 0;
    end else begin
      cyc = cyc + 1;
    end
    if (p_sclk && !dac_sclk) begin
      if (dac_sync) bad_falls = bad_falls + 1;
      else begin
        cap = {cap[22:0], dac_din};
        falls = falls + 1;
      end
    end
    if (!dac_sync && !dac_sclk && !p_sclk && (dac_din != p_din))
      glitches = glitches + 1;
    if (dac_sync && !p_sync) begin
      sync_w = 1; sync_rises = sync_rises + 1;
    end else if (dac_sync) begin
      sync_w = sync_w + 1;
    end else if (p_sync) begin
      sync_w_last = sync_w;
    end
    if (done) begin
      done_at = cyc; done_cnt = done_cnt + 1;
    end
    p_sclk = dac_sclk; p_sync = dac_sync; p_busy = busy; p_din = dac_din;
    if (wd > 150000) begin
      n_chk = n_chk + 1; n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] c, input logic [1:0] m);
    @(negedge clk);
    req_code = c; req_mode = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int base);
    int n = 0;
    while (done_cnt == base && n < 1000) begin
      @(negedge clk);
      n = n + 1;
    end
    @(negedge clk);
    check("R7 done seen", (done_cnt > base) ? 32'd1 : 32'd0, 32'd1);
  endtask

  initial begin
    req_valid = 1'b0; req_code = '0; req_mode = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs while reset is held
    check("R8 sync in reset", {31'd0, dac_sync}, 32'd0);
    check("R8 sclk in reset", {31'd0, dac_sclk}, 32'd1);
    check("R8 din in reset", {31'd0, dac_din}, 32'd0);
    check("R8 busy/done in reset", {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R8 idle lines after reset", {29'd0, dac_sync, dac_sclk, busy}, 32'd2);

    // R1 R2 R3 R4 R5 R7 R9: table of frames
    for (int i = 0; i < NVEC; i++) begin
      int base;
      base = done_cnt;
      issue(VEC[i][15:0], VEC[i][17:16]);
      check("R7 busy after accept", {31'd0, busy}, 32'd1);
      check("R6 ready low in transfer", {31'd0, req_ready}, 32'd0);
      wait_done(base);
      check("R1 R2 word", {8'd0, cap}, {8'd0, 6'd0, VEC[i]});
      check("R4 falling edges", falls, 24);
      check("R3 sync high width", sync_w_last, SYNC_EXP);
      check("R7 latency", done_at, LAT_EXP);
      check("R7 busy low at done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      check("R9 sclk back high", {31'd0, dac_sclk}, 32'd1);
      check("R9 ready/sync/din", {29'd0, req_ready, dac_sync, dac_din}, 32'd4);
      check("R7 done one cycle", {31'd0, done}, 32'd0);
    end

    // R6: a request during a transfer is ignored
    begin
      int base, rises;
      base = done_cnt;
      rises = sync_rises;
      issue(16'h3C5A, 2'b10);
      repeat (20) @(negedge clk);
      req_code = 16'h1234; req_mode = 2'b01; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done(base);
      check("R6 word unaffected", {8'd0, cap}, {8'd0, 6'd0, 2'b10, 16'h3C5A});
      repeat (20) @(negedge clk);
      check("R6 no extra frame", sync_rises - rises, 1);
      check("R3 sync idles low", {31'd0, dac_sync}, 32'd0);
    end

    // R5 R4: global monitors
    check("R5 data stable while sclk low", glitches, 0);
    check("R4 no fall with sync high", bad_falls, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule